// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block holds a byte-wide transmit queue and a byte-wide receive queue between a register port and a serial shift engine. It also produces one interrupt line from those queues. Software fills the transmit queue and drains the receive queue through data registers. The shift engine pops transmit bytes and pushes receive bytes through its own strobe ports. Each queue has a trigger level that software sets, and a fill count that software can read back. Each queue can be flushed by a command bit that clears itself.

The interrupt status word mixes two kinds of bits:

- **Live bits** follow the queue state: threshold requests, empty and full.
- **Sticky bits** record error and event conditions: overrun, underrun, transfer done and chip-select release. Writing a one to a sticky bit clears it.

The interrupt output goes high whenever any status bit is set and its enable bit is also set.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the following hold. Both fill counts are 0. Both trigger levels are 0. The enables are 0 and `irq` is 0. The status word (register index 3) reads 0x33: receive ready (bit 0), receive empty (bit 1), transmit request (bit 4) and transmit empty (bit 5).
- R2: Bytes leave each queue in the order they entered. Transmit bytes are written at register index 4 and popped with `txPop`. Receive bytes are pushed with `rxPush` and read at register index 5. The fill-status word (index 1) reports the transmit count in bits 23:16 and the receive count in bits 7:0. Each queue holds up to DEPTH (64) bytes.
- R3: Status bit 4 (transmit request) is 1 exactly while the transmit count is less than or equal to the transmit trigger. The transmit trigger is bits 23:16 of the control word (index 0).
- R4: Status bit 0 (receive ready) is 1 exactly while the receive count is greater than or equal to the receive trigger. The receive trigger is bits 7:0 of the control word.
- R5: Status bits 1 and 5 are 1 while the receive or transmit queue, respectively, is empty. Bits 2 and 6 are 1 while the receive or transmit queue, respectively, holds DEPTH bytes.
- R6: Writing 1 to control bit 31 flushes the transmit queue; writing 1 to bit 15 flushes the receive queue. The bit reads 1 in the cycle after the write and 0 from the next cycle on, by which time that queue's count is 0. The other queue keeps its contents.
- R7: A register write to a full transmit queue drops the byte, leaves the count at DEPTH, and sets sticky bit 10.
- R8: A register read of an empty receive queue returns 0 and sets sticky bit 9.
- R9: A `rxPush` into a full receive queue drops the byte and sets sticky bit 8. A `txPop` from an empty transmit queue sets sticky bit 11; while the queue is empty, `txPopValid` is 0 and `txPopData` is 0.
- R10: A one-cycle pulse on `xferDone` sets sticky bit 12. A one-cycle pulse on `csRelease` sets sticky bit 13.
- R11: Writing 1 to a sticky bit in the status word clears it. Writing 0 to a sticky bit leaves it unchanged. Writes to the live bits have no effect. A set event in the same cycle as the clear wins.
- R12: `irq` is the OR of all status bits ANDed with the enable word (index 2). The enable word keeps only the defined bits and reads back as the write data ANDed with 0x3F77.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops receive data at index 5) |
| regAddr | input | 3 | Register index: 0 control, 1 fill status, 2 enable, 3 status, 4 transmit data, 5 receive data |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| txPop | input | 1 | Engine pops one transmit byte |
| txPopData | output | 8 | Head of the transmit queue, 0 when empty |
| txPopValid | output | 1 | Transmit queue not empty |
| rxPush | input | 1 | Engine pushes one receive byte |
| rxPushData | input | 8 | Byte pushed by the engine |
| xferDone | input | 1 | Transfer-complete event pulse |
| csRelease | input | 1 | Chip-select deassert event pulse |
| irq | output | 1 | Masked interrupt request |

## Verification
The queues are exercised with several traffic patterns:

- Short runs of distinct bytes, to show ordering.
- A fill past capacity, to show the dropped byte, the full flag and overrun.
- A pop or read of an empty queue, to show underrun and the zero data.

The threshold bits are tested with counts at, just below and just above a non-zero trigger, which separates the "at or below" and "at or above" comparisons from strict ones. The flush commands are issued with the other queue holding data, so a flush that reaches the wrong queue shows up. The enable mask is tested against both sticky and live sources, including a live source that drops when one byte is written.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam logic [2:0] ADDR_FCTL  = 3'd0;
  localparam logic [2:0] ADDR_FSTAT = 3'd1;
  localparam logic [2:0] ADDR_IEN   = 3'd2;
  localparam logic [2:0] ADDR_ISTAT = 3'd3;
  localparam logic [2:0] ADDR_TXD   = 3'd4;
  localparam logic [2:0] ADDR_RXD   = 3'd5;

  localparam int TRIG_W = 8;
  localparam int STAT_W = 14;
  localparam int STK_N  = 6;
  localparam int STK_LO = 8;

  // sticky indices (status bit = STK_LO + index)
  localparam int STK_RXOVF = 0;
  localparam int STK_RXUDR = 1;
  localparam int STK_TXOVF = 2;
  localparam int STK_TXUDR = 3;
  localparam int STK_DONE  = 4;
  localparam int STK_CSREL = 5;

  localparam logic [STAT_W-1:0] IEN_MASK = 14'h3F77;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClear;
    logic rxClear;
  } fifoStrobeT;
endpackage

// File: rtl/fic_fifo.sv
module fic_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wrData,
  input  logic                       pop,
  input  logic                       clear,
  output logic [WIDTH-1:0]           rdData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH+1);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic              doPush, doPop, isFull, isEmpty;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);
  assign doPush  = push && !isFull && !clear;
  assign doPop   = pop && !isEmpty && !clear;
  assign rdData  = isEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fic_datapath.sv
module fic_datapath import fic_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobeT       strobes,
  input  logic [WIDTH-1:0] txWrData,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  output logic [WIDTH-1:0] txHead,
  output logic [WIDTH-1:0] rxHead,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount
);
  fic_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .wrData(txWrData),
    .pop(txPop), .clear(strobes.txClear),
    .rdData(txHead), .count(txCount)
  );

  fic_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .wrData(rxPushData),
    .pop(strobes.rxPop), .clear(strobes.rxClear),
    .rdData(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/fic_control.sv
module fic_control import fic_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH+1),
  localparam int CMP_W = TRIG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic              xferDone,
  input  logic              csRelease,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [WIDTH-1:0]  rxHead,
  output fifoStrobeT        strobes,
  output logic              irq,
  output logic [STK_N-1:0]  stickyBits,
  output logic [STAT_W-1:0] irqEnable,
  output logic              txRstPend,
  output logic              rxRstPend
);
  logic [TRIG_W-1:0] txTrig, rxTrig;
  logic wrFctl, wrIen, wrIstat, wrTxd, rdRxd;
  logic txFull, txEmpty, rxFull, rxEmpty, txReq, rxReady;
  logic [STK_N-1:0]  stkSet, stkClr;
  logic [STAT_W-1:0] statusWord;
  logic [CMP_W-1:0]  txCntX, rxCntX, txTrigX, rxTrigX;

  assign wrFctl  = regWrEn && (regAddr == ADDR_FCTL);
  assign wrIen   = regWrEn && (regAddr == ADDR_IEN);
  assign wrIstat = regWrEn && (regAddr == ADDR_ISTAT);
  assign wrTxd   = regWrEn && (regAddr == ADDR_TXD);
  assign rdRxd   = regRdEn && (regAddr == ADDR_RXD);

  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxFull  = (rxCount == CNT_W'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);

  assign txCntX  = CMP_W'(txCount);
  assign rxCntX  = CMP_W'(rxCount);
  assign txTrigX = CMP_W'(txTrig);
  assign rxTrigX = CMP_W'(rxTrig);
  assign txReq   = (txCntX <= txTrigX);
  assign rxReady = (rxCntX >= rxTrigX);

  assign strobes.txPush  = wrTxd && !txFull;
  assign strobes.rxPop   = rdRxd && !rxEmpty;
  assign strobes.txClear = txRstPend;
  assign strobes.rxClear = rxRstPend;

  always_comb begin
    stkSet = '0;
    stkSet[STK_RXOVF] = rxPush && rxFull;
    stkSet[STK_RXUDR] = rdRxd && rxEmpty;
    stkSet[STK_TXOVF] = wrTxd && txFull;
    stkSet[STK_TXUDR] = txPop && txEmpty;
    stkSet[STK_DONE]  = xferDone;
    stkSet[STK_CSREL] = csRelease;
    stkClr = wrIstat ? regWrData[STK_LO +: STK_N] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txTrig     <= '0;
      rxTrig     <= '0;
      txRstPend  <= 1'b0;
      rxRstPend  <= 1'b0;
      irqEnable  <= '0;
      stickyBits <= '0;
    end else begin
      txRstPend <= 1'b0;
      rxRstPend <= 1'b0;
      if (wrFctl) begin
        txTrig    <= regWrData[23:16];
        rxTrig    <= regWrData[7:0];
        txRstPend <= regWrData[31];
        rxRstPend <= regWrData[15];
      end
      if (wrIen) irqEnable <= regWrData[STAT_W-1:0] & IEN_MASK;
      stickyBits <= (stickyBits & ~stkClr) | stkSet;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[0] = rxReady;
    statusWord[1] = rxEmpty;
    statusWord[2] = rxFull;
    statusWord[4] = txReq;
    statusWord[5] = txEmpty;
    statusWord[6] = txFull;
    statusWord[STK_LO +: STK_N] = stickyBits;
  end

  assign irq = |(statusWord & irqEnable);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_FCTL:  regRdData = {txRstPend, 7'b0, txTrig, rxRstPend, 7'b0, rxTrig};
      ADDR_FSTAT: begin
        regRdData[16 +: CNT_W] = txCount;
        regRdData[0  +: CNT_W] = rxCount;
      end
      ADDR_IEN:   regRdData[STAT_W-1:0] = irqEnable;
      ADDR_ISTAT: regRdData[STAT_W-1:0] = statusWord;
      ADDR_RXD:   regRdData[WIDTH-1:0]  = rxHead;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl import fic_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  output logic             txPopValid,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             xferDone,
  input  logic             csRelease,
  output logic             irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  fifoStrobeT        strobes;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [WIDTH-1:0]  rxHead;
  logic [STK_N-1:0]  stickyBits;
  logic [STAT_W-1:0] irqEnable;
  logic              txRstPend, rxRstPend;

  assign txPopValid = (txCount != '0);

  fic_control #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txPop(txPop), .rxPush(rxPush),
    .xferDone(xferDone), .csRelease(csRelease),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .strobes(strobes), .irq(irq),
    .stickyBits(stickyBits), .irqEnable(irqEnable),
    .txRstPend(txRstPend), .rxRstPend(rxRstPend)
  );

  fic_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txWrData(regWrData[WIDTH-1:0]), .txPop(txPop),
    .rxPush(rxPush), .rxPushData(rxPushData),
    .txHead(txPopData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/fic_checker.sv
module fic_checker import fic_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [2:0]        regAddr,
  input logic              wrBit12,
  input logic              txPop,
  input logic              irq,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic [STK_N-1:0]  stickyBits,
  input logic [STAT_W-1:0] irqEnable,
  input logic              txRstPend
);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));

  p_tx_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    txRstPend |=> (txCount == '0) && !txRstPend);

  p_tx_overrun_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_TXD && txCount == CNT_W'(DEPTH) && !txRstPend && !txPop)
    |=> (txCount == CNT_W'(DEPTH)) && stickyBits[STK_TXOVF]);

  p_rx_underrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_RXD && rxCount == '0) |=> stickyBits[STK_RXUDR]);

  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stickyBits[STK_DONE] && !(regWrEn && regAddr == ADDR_ISTAT && wrBit12))
    |=> stickyBits[STK_DONE]);

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable == '0) |-> !irq);
endmodule

bind fifo_irq_ctrl fic_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .wrBit12(regWrData[12]), .txPop(txPop), .irq(irq),
  .txCount(txCount), .rxCount(rxCount), .stickyBits(stickyBits),
  .irqEnable(irqEnable), .txRstPend(txRstPend)
);

// File: tb/sim_fifo_irq_ctrl.sv
module sim_fifo_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic txPop = 0;
  logic [7:0] txPopData;
  logic txPopValid;
  logic rxPush = 0;
  logic [7:0] rxPushData = 0;
  logic xferDone = 0, csRelease = 0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH), .WIDTH(8)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txPop(txPop), .txPopData(txPopData), .txPopValid(txPopValid),
    .rxPush(rxPush), .rxPushData(rxPushData),
    .xferDone(xferDone), .csRelease(csRelease), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); #1;
    regRdEn = 0;
  endtask

  task automatic engPop(output logic [7:0] d, output logic v);
    @(negedge clk);
    txPop = 1;
    #1 d = txPopData; v = txPopValid;
    @(posedge clk); #1;
    txPop = 0;
  endtask

  task automatic engPush(input logic [7:0] d);
    @(negedge clk);
    rxPush = 1; rxPushData = d;
    @(posedge clk); #1;
    rxPush = 0;
  endtask

  task automatic tReset();
    logic [31:0] r;
    regRd(3'd3, r); chk("R1 status after reset", r, 32'h33);
    regRd(3'd0, r); chk("R1 control after reset", r, 32'h0);
    regRd(3'd1, r); chk("R1 fill after reset", r, 32'h0);
    regRd(3'd2, r); chk("R1 enable after reset", r, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic tTxOrder();
    logic [31:0] r; logic [7:0] d; logic v;
    regWr(3'd4, 32'hA1); regWr(3'd4, 32'hB2); regWr(3'd4, 32'hC3);
    regRd(3'd1, r); chk("R2 tx count 3", r, 32'h0003_0000);
    engPop(d, v); chk("R2 tx pop 1", {24'b0, d}, 32'hA1);
    engPop(d, v); chk("R2 tx pop 2", {24'b0, d}, 32'hB2);
    engPop(d, v); chk("R2 tx pop 3", {24'b0, d}, 32'hC3);
    regRd(3'd1, r); chk("R2 tx drained", r, 32'h0);
  endtask

  task automatic tRxOrder();
    logic [31:0] r;
    for (int i = 1; i <= 5; i++) engPush(8'(i * 16));
    regRd(3'd1, r); chk("R2 rx count 5", r, 32'h5);
    for (int i = 1; i <= 5; i++) begin
      regRd(3'd5, r); chk("R2 rx read order", r, 32'(i * 16));
    end
    regRd(3'd1, r); chk("R2 rx drained", r, 32'h0);
  endtask

  task automatic tThresh();
    logic [31:0] r;
    regWr(3'd0, 32'h0002_0003);
    regRd(3'd3, r); chk("R3 R4 empty with triggers 2/3", r & 32'h11, 32'h10);
    regWr(3'd4, 32'h1); regWr(3'd4, 32'h2);
    regRd(3'd3, r); chk("R3 tx count equal to trigger", r & 32'h10, 32'h10);
    regWr(3'd4, 32'h3);
    regRd(3'd3, r); chk("R3 tx count above trigger", r & 32'h10, 32'h0);
    engPush(8'h1); engPush(8'h2);
    regRd(3'd3, r); chk("R4 rx count below trigger", r & 32'h01, 32'h0);
    engPush(8'h3);
    regRd(3'd3, r); chk("R4 rx count equal to trigger", r & 32'h01, 32'h1);
    regWr(3'd0, 32'h8000_8000);
    regRd(3'd1, r);
    regRd(3'd1, r); chk("R6 both queues flushed", r, 32'h0);
  endtask

  task automatic tFull();
    logic [31:0] r; logic [7:0] d; logic v;
    for (int i = 0; i < DEPTH; i++) regWr(3'd4, 32'(i));
    regRd(3'd3, r); chk("R5 tx full not empty", r & 32'h60, 32'h40);
    regWr(3'd4, 32'hEE);
    regRd(3'd3, r); chk("R7 tx overrun flag", r & 32'h400, 32'h400);
    regRd(3'd1, r); chk("R7 tx count stays at depth", r, 32'h0040_0000);
    for (int i = 0; i < DEPTH; i++) begin
      engPop(d, v);
      if (d !== 8'(i)) chk("R7 tx content after drop", {24'b0, d}, 32'(i));
    end
    chk("R7 last popped byte", {24'b0, d}, 32'(DEPTH - 1));
    engPop(d, v);
    chk("R9 pop empty data", {23'b0, v, d}, 32'h0);
    regRd(3'd3, r); chk("R9 tx underrun and empty", r & 32'h860, 32'h820);
  endtask

  task automatic tRxOvf();
    logic [31:0] r;
    for (int i = 0; i < DEPTH; i++) engPush(8'(i));
    regRd(3'd3, r); chk("R5 rx full not empty", r & 32'h06, 32'h04);
    engPush(8'hEE);
    regRd(3'd3, r); chk("R9 rx overrun flag", r & 32'h100, 32'h100);
    regRd(3'd1, r); chk("R9 rx count stays at depth", r, 32'h40);
  endtask

  task automatic tFlush();
    logic [31:0] r;
    regWr(3'd4, 32'h55); regWr(3'd4, 32'h66);
    regWr(3'd0, 32'h0000_8000);
    regRd(3'd0, r); chk("R6 rx flush bit pending", r, 32'h0000_8000);
    regRd(3'd0, r); chk("R6 rx flush bit self-clears", r, 32'h0);
    regRd(3'd1, r); chk("R6 rx flushed, tx kept", r, 32'h0002_0000);
    regWr(3'd0, 32'h8000_0000);
    regRd(3'd0, r); chk("R6 tx flush bit pending", r, 32'h8000_0000);
    regRd(3'd0, r); chk("R6 tx flush bit self-clears", r, 32'h0);
    regRd(3'd1, r); chk("R6 tx flushed", r, 32'h0);
  endtask

  task automatic tUnderrun();
    logic [31:0] r;
    regRd(3'd5, r); chk("R8 empty rx read returns 0", r, 32'h0);
    regRd(3'd3, r); chk("R8 rx underrun flag", r & 32'h200, 32'h200);
  endtask

  task automatic tEvents();
    logic [31:0] r;
    regWr(3'd3, 32'h3F00);
    regRd(3'd3, r); chk("R11 all sticky cleared", r & 32'h3F00, 32'h0);
    @(negedge clk); xferDone = 1; @(posedge clk); #1 xferDone = 0;
    regRd(3'd3, r); chk("R10 transfer done flag", r & 32'h3F00, 32'h1000);
    @(negedge clk); csRelease = 1; @(posedge clk); #1 csRelease = 0;
    regRd(3'd3, r); chk("R10 chip-select release flag", r & 32'h3F00, 32'h3000);
  endtask

  task automatic tW1c();
    logic [31:0] r;
    regWr(3'd3, 32'h1000);
    regRd(3'd3, r); chk("R11 clear one sticky bit", r & 32'h3F00, 32'h2000);
    regWr(3'd3, 32'h0000_00FF);
    regRd(3'd3, r); chk("R11 zero bits leave sticky", r & 32'h3F00, 32'h2000);
    chk("R11 live bits unaffected by write", r & 32'h77, 32'h33);
    @(negedge clk);
    regWrEn = 1; regAddr = 3'd3; regWrData = 32'h1000; xferDone = 1;
    @(posedge clk); #1;
    regWrEn = 0; xferDone = 0;
    regRd(3'd3, r); chk("R11 set wins over clear", r & 32'h3F00, 32'h3000);
  endtask

  task automatic tIrq();
    logic [31:0] r;
    chk("R12 irq low with enables 0", {31'b0, irq}, 32'h0);
    regWr(3'd2, 32'hFFFF_FFFF);
    regRd(3'd2, r); chk("R12 enable readback mask", r, 32'h3F77);
    chk("R12 irq with all enables", {31'b0, irq}, 32'h1);
    regWr(3'd2, 32'h2000);
    chk("R12 irq from cs release", {31'b0, irq}, 32'h1);
    regWr(3'd3, 32'h3000);
    chk("R12 irq drops after clear", {31'b0, irq}, 32'h0);
    regWr(3'd2, 32'h0010);
    chk("R12 irq from tx request level", {31'b0, irq}, 32'h1);
    regWr(3'd4, 32'h77);
    chk("R12 irq drops as tx fill passes trigger", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tReset();
    tTxOrder();
    tRxOrder();
    tThresh();
    tFull();
    tRxOvf();
    tFlush();
    tUnderrun();
    tEvents();
    tW1c();
    tIrq();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule